// File: doc/BRIEF.md
# Two-Way Cache Maintenance Engine

This block keeps the tag, valid and modified bits of a small two-way set-associative cache and runs maintenance operations over them. A caller presents an operation code, a flag that selects either one line (chosen by physical address) or the whole array, and a one-cycle start strobe. The engine reports busy while it works and pulses done when it finishes.

Whenever an operation has to write a dirty line back, the engine raises a writeback request carrying the line address and holds it until the acknowledge arrives. No line data passes through the block; the request/acknowledge pair stands in for the transfer. A search operation records lines and modified marks, and it reports hit, way and dirty status. This gives the surrounding logic, and a test, a way to see the stored state.

Top module: `cache_maint_2way`

## Requirements
- R1: After reset every entry in both ways is invalid and unmodified, and busy, done and wb_req are all 0.
- R2: Operation code 0 (search) looks up the address in both ways. A write (cmd_wr=1) that hits sets the modified bit of the matching entry. A write that misses installs the tag into way cmd_way with valid and modified set. A read leaves the state unchanged.
- R3: A line address uses bits [11:4] as the set and bits [31:12] as the tag. Bits [3:0] are ignored, and wb_addr always has them at zero.
- R4: Operation code 1 (invalidate) clears valid and modified on the matching entry and never raises wb_req.
- R5: Operation code 2 (push) writes back an entry only when it is valid and modified, then clears modified and keeps valid. Any other entry is left as it is.
- R6: Operation code 3 (clear) writes back a valid and modified entry, then clears valid and modified. A valid but clean entry only loses its valid bit, with no writeback.
- R7: A line operation whose tag matches no valid way changes no state, raises no writeback and still finishes with done.
- R8: With cmd_all=1, operations 1 to 3 visit every entry, set 0 up to set 255, with way 0 before way 1 in each set. Operation 0 with cmd_all=1 finishes with no change.
- R9: wb_req stays high with a stable wb_addr until wb_ack is seen, and the operation does not advance meanwhile.
- R10: done is high for exactly one cycle, the same cycle busy returns to 0. A start while busy is ignored.
- R11: For a line operation, rsp_hit, rsp_way and rsp_dirty give the matching entry as it was before the operation, and are 0 on a miss or for a whole-array operation. They stay valid from done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start strobe, sampled when not busy |
| cmd_op | input | 2 | 0 search, 1 invalidate, 2 push, 3 clear |
| cmd_all | input | 1 | 1 selects the whole array, 0 a single line |
| cmd_addr | input | 32 | Physical address of the target line |
| cmd_wr | input | 1 | Search is a write (marks or installs a modified line) |
| cmd_way | input | 1 | Way that receives a line installed on a write miss |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Line operation found a matching entry |
| rsp_way | output | 1 | Way of the matching entry |
| rsp_dirty | output | 1 | Matching entry was modified before the operation |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | 32 | Line-aligned address of the entry being written back |
| wb_ack | input | 1 | Writeback acknowledge |

## Verification
The assertions assume two things about the inputs. wb_ack is raised only while wb_req is high, and only once per request. A start strobe is a single-cycle pulse. The stimulus answers each request after a delay of zero to three cycles and drops the acknowledge on the next cycle. It pulses start for one cycle only, and it issues one start on purpose during a whole-array walk to show that such a start is ignored. Command fields are driven together with the strobe and are not sampled at any other time.

// File: rtl/cache_maint_2way.sv
module cache_maint_2way #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int SET_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_all,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_wr,
  input  logic              cmd_way,
  output logic              busy,
  output logic              done,
  output logic              rsp_hit,
  output logic              rsp_way,
  output logic              rsp_dirty,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack
);
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam logic [1:0] OP_SRCH = 2'd0, OP_INV = 2'd1, OP_PUSH = 2'd2, OP_CLR = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WALK, S_WB} st_t;

  st_t              st;
  logic [1:0]       op_q;
  logic             all_q, wr_q, fill_w, cur_w;
  logic [SET_W-1:0] set_q;
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] tags [2][SETS];
  logic [SETS-1:0]  vld [2];
  logic [SETS-1:0]  mdf [2];
  logic             done_q, rh_q, rw_q, rd_q;

  logic unused_lo;
  assign unused_lo = ^cmd_addr[OFF_W-1:0];

  wire hit0    = vld[0][set_q] && (tags[0][set_q] == tag_q);
  wire hit1    = vld[1][set_q] && (tags[1][set_q] == tag_q);
  wire any_hit = hit0 | hit1;
  wire hw      = !hit0;
  wire ew      = (st == S_LOOK) ? hw : cur_w;
  wire ev      = vld[ew][set_q];
  wire em      = mdf[ew][set_q];
  wire need_wb = op_q[1] && ev && em;
  wire last    = (&set_q) && cur_w;
  wire act     = (st == S_WALK) || (st == S_LOOK && any_hit && op_q != OP_SRCH);
  wire ack_go  = (st == S_WB) && wb_ack;
  wire step    = (act && !need_wb) || ack_go;

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign rsp_hit   = rh_q;
  assign rsp_way   = rw_q;
  assign rsp_dirty = rd_q;
  assign wb_req    = (st == S_WB);
  assign wb_addr   = {tags[cur_w][set_q], set_q, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= OP_SRCH;
      all_q <= 1'b0;
      wr_q <= 1'b0;
      fill_w <= 1'b0;
      cur_w <= 1'b0;
      set_q <= '0;
      tag_q <= '0;
      done_q <= 1'b0;
      rh_q <= 1'b0;
      rw_q <= 1'b0;
      rd_q <= 1'b0;
      for (int w = 0; w < 2; w++) begin
        vld[w] <= '0;
        mdf[w] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_start) begin
          op_q   <= cmd_op;
          all_q  <= cmd_all;
          wr_q   <= cmd_wr;
          fill_w <= cmd_way;
          tag_q  <= cmd_addr[ADDR_W-1 -: TAG_W];
          rh_q <= 1'b0;
          rw_q <= 1'b0;
          rd_q <= 1'b0;
          if (cmd_all) begin
            set_q <= '0;
            cur_w <= 1'b0;
            if (cmd_op == OP_SRCH) done_q <= 1'b1;
            else st <= S_WALK;
          end else begin
            set_q <= cmd_addr[OFF_W +: SET_W];
            st    <= S_LOOK;
          end
        end
        S_LOOK: begin
          rh_q  <= any_hit;
          rw_q  <= any_hit & hw;
          rd_q  <= any_hit & em;
          cur_w <= hw;
          if (op_q == OP_SRCH) begin
            if (any_hit && wr_q) mdf[hw][set_q] <= 1'b1;
            else if (!any_hit && wr_q) begin
              tags[fill_w][set_q] <= tag_q;
              vld[fill_w][set_q]  <= 1'b1;
              mdf[fill_w][set_q]  <= 1'b1;
            end
            st <= S_IDLE;
            done_q <= 1'b1;
          end else if (!any_hit) begin
            st <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: ;
      endcase

      if (act) begin
        if (need_wb) st <= S_WB;
        else if (op_q == OP_INV) begin
          vld[ew][set_q] <= 1'b0;
          mdf[ew][set_q] <= 1'b0;
        end else if (op_q == OP_CLR) vld[ew][set_q] <= 1'b0;
      end

      if (ack_go) begin
        mdf[cur_w][set_q] <= 1'b0;
        if (op_q == OP_CLR) vld[cur_w][set_q] <= 1'b0;
      end

      if (step) begin
        if (!all_q || last) begin
          st <= S_IDLE;
          done_q <= 1'b1;
        end else begin
          st <= S_WALK;
          {set_q, cur_w} <= {set_q, cur_w} + 1'b1;
        end
      end
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_start));
  a_r9_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));
  a_r4_inv_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (op_q == OP_PUSH || op_q == OP_CLR));
  a_r5_push_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_ack && op_q == OP_PUSH) |=> (vld[cur_w] != '0));
endmodule

// File: tb/sim_cache_maint_2way.sv
`timescale 1ns/1ps
module sim_cache_maint_2way;
  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_all = 0, cmd_wr = 0, cmd_way = 0;
  logic [1:0] cmd_op = 0;
  logic [31:0] cmd_addr = 0;
  logic wb_ack = 0;
  logic busy, done, rsp_hit, rsp_way, rsp_dirty, wb_req;
  logic [31:0] wb_addr;

  always #2 clk = ~clk;

  cache_maint_2way u0 (.clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_all(cmd_all), .cmd_addr(cmd_addr), .cmd_wr(cmd_wr), .cmd_way(cmd_way),
    .busy(busy), .done(done), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_dirty(rsp_dirty),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack));

  int n_cmp = 0, n_bad = 0, n_ack = 0, dly = 0;
  logic [19:0] mt [2][256];
  bit mv [2][256];
  bit mm [2][256];
  logic [31:0] q_wb[$];
  string q_wb_rq[$];
  logic [2:0] q_rsp[$];
  string q_rsp_rq[$];

  function automatic logic [31:0] mk(input int t, input int s, input int o);
    return {t[19:0], s[7:0], o[3:0]};
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input int w, input int s, input string rq);
    if (op == 2'd1) begin mv[w][s] = 0; mm[w][s] = 0; end
    else if (mv[w][s] && mm[w][s]) begin
      q_wb.push_back({mt[w][s], s[7:0], 4'h0});
      q_wb_rq.push_back(rq);
      if (op == 2'd2) mm[w][s] = 0;
      else begin mv[w][s] = 0; mm[w][s] = 0; end
    end else if (op == 2'd3) mv[w][s] = 0;
  endtask

  task automatic issue(input logic [1:0] op, input bit all, input logic [31:0] a,
                       input bit wr, input bit way, input string rq);
    if (all) begin
      q_rsp.push_back(3'b000); q_rsp_rq.push_back(rq);
      if (op != 2'd0)
        for (int s = 0; s < 256; s++)
          for (int w = 0; w < 2; w++) apply(op, w, s, rq);
    end else begin
      int s = a[11:4];
      logic [19:0] t = a[31:12];
      bit h0 = mv[0][s] && mt[0][s] == t;
      bit h1 = mv[1][s] && mt[1][s] == t;
      bit hit = h0 | h1;
      int hw = h0 ? 0 : 1;
      q_rsp.push_back({hit, hit && hw == 1, hit && mm[hw][s]});
      q_rsp_rq.push_back(rq);
      if (op == 2'd0) begin
        if (hit && wr) mm[hw][s] = 1;
        else if (!hit && wr) begin mt[way][s] = t; mv[way][s] = 1; mm[way][s] = 1; end
      end else if (hit) apply(op, hw, s, rq);
    end
    @(negedge clk);
    cmd_op = op; cmd_all = all; cmd_addr = a; cmd_wr = wr; cmd_way = way; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic wait_done(input string rq);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(rq, "done one cycle, idle after", {done, busy}, 2'b00);
  endtask

  task automatic run(input logic [1:0] op, input bit all, input logic [31:0] a,
                     input bit wr, input bit way, input string rq);
    issue(op, all, a, wr, way, rq);
    wait_done(rq);
  endtask

  always @(negedge clk) begin
    if (!rst_n) wb_ack = 0;
    else begin
      if (done) begin
        if (q_rsp.size() == 0) chk("R10", "unexpected done", 1, 0);
        else begin
          string rq = q_rsp_rq.pop_front();
          chk(rq, "response hit/way/dirty", {rsp_hit, rsp_way, rsp_dirty}, q_rsp.pop_front());
        end
      end
      if (wb_ack) wb_ack = 0;
      else if (wb_req) begin
        if (dly > 0) dly--;
        else begin
          if (q_wb.size() == 0) chk("R9", "unexpected writeback", wb_addr, 32'hx);
          else begin
            string rq = q_wb_rq.pop_front();
            chk(rq, "writeback address", wb_addr, q_wb.pop_front());
          end
          wb_ack = 1;
          n_ack++;
          dly = n_ack % 4;
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog R10: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "busy/done/wb_req after reset", {busy, done, wb_req}, 3'b000);
    run(2'd0, 0, mk(20'h12345, 3, 0), 0, 0, "R1");
    run(2'd2, 1, 0, 0, 0, "R1");
    // R2: install and mark through search
    run(2'd0, 0, mk(20'h00A11, 7, 0), 1, 0, "R2");
    run(2'd0, 0, mk(20'h00A11, 7, 0), 0, 0, "R2");
    run(2'd0, 0, mk(20'h00B22, 7, 0), 1, 1, "R2");
    run(2'd0, 0, mk(20'h00B22, 7, 0), 0, 0, "R2");
    // R3: low offset bits ignored
    run(2'd0, 0, mk(20'h00A11, 7, 15), 0, 0, "R3");
    // R5: push dirty then clean
    run(2'd2, 0, mk(20'h00B22, 7, 6), 0, 0, "R5");
    run(2'd0, 0, mk(20'h00B22, 7, 0), 0, 0, "R5");
    run(2'd2, 0, mk(20'h00B22, 7, 0), 0, 0, "R5");
    // R6: clear clean then dirty
    run(2'd3, 0, mk(20'h00B22, 7, 0), 0, 0, "R6");
    run(2'd0, 0, mk(20'h00B22, 7, 0), 0, 0, "R6");
    run(2'd3, 0, mk(20'h00A11, 7, 9), 0, 0, "R6");
    run(2'd0, 0, mk(20'h00A11, 7, 0), 0, 0, "R6");
    // R4: invalidate dirty, no writeback
    run(2'd0, 0, mk(20'h0C0C0, 40, 0), 1, 1, "R4");
    run(2'd1, 0, mk(20'h0C0C0, 40, 0), 0, 0, "R4");
    run(2'd0, 0, mk(20'h0C0C0, 40, 0), 0, 0, "R4");
    // R7: misses
    run(2'd2, 0, mk(20'h0DEAD, 41, 0), 0, 0, "R7");
    run(2'd3, 0, mk(20'h0DEAD, 41, 0), 0, 0, "R7");
    run(2'd1, 0, mk(20'h0DEAD, 41, 0), 0, 0, "R7");
    // R2: write hit on clean line
    run(2'd0, 0, mk(20'h0D0D0, 50, 0), 1, 0, "R2");
    run(2'd2, 0, mk(20'h0D0D0, 50, 0), 0, 0, "R2");
    run(2'd0, 0, mk(20'h0D0D0, 50, 0), 1, 0, "R2");
    run(2'd0, 0, mk(20'h0D0D0, 50, 0), 0, 0, "R11");
    // R8: whole-array walk order, with an ignored start (R10)
    run(2'd0, 0, mk(20'h10000, 0, 0), 1, 0, "R8");
    run(2'd0, 0, mk(20'h10001, 0, 0), 1, 1, "R8");
    run(2'd0, 0, mk(20'h10005, 5, 0), 1, 1, "R8");
    run(2'd0, 0, mk(20'h100FF, 255, 0), 1, 0, "R8");
    run(2'd0, 0, mk(20'h1FFFF, 255, 0), 1, 1, "R8");
    run(2'd0, 0, mk(20'h20009, 9, 0), 1, 0, "R10");
    run(2'd2, 0, mk(20'h20009, 9, 0), 0, 0, "R10");
    issue(2'd2, 1, 0, 0, 0, "R8");
    repeat (4) @(negedge clk);
    cmd_op = 2'd1; cmd_all = 0; cmd_addr = mk(20'h20009, 9, 0); cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    wait_done("R8");
    run(2'd0, 0, mk(20'h20009, 9, 0), 0, 0, "R10");
    run(2'd0, 0, mk(20'h1FFFF, 255, 0), 0, 0, "R8");
    run(2'd0, 0, mk(20'h10000, 0, 0), 1, 0, "R8");
    run(2'd3, 1, 0, 0, 0, "R8");
    run(2'd0, 0, mk(20'h1FFFF, 255, 0), 0, 0, "R8");
    run(2'd0, 0, mk(20'h20009, 9, 0), 0, 0, "R8");
    // R8: whole invalidate and whole search
    run(2'd0, 0, mk(20'h30003, 3, 0), 1, 1, "R8");
    run(2'd0, 0, mk(20'h30004, 4, 0), 1, 0, "R8");
    run(2'd1, 1, 0, 0, 0, "R8");
    run(2'd0, 0, mk(20'h30003, 3, 0), 0, 0, "R8");
    run(2'd0, 0, mk(20'h30004, 4, 0), 1, 1, "R8");
    run(2'd0, 1, 0, 0, 0, "R8");
    run(2'd0, 0, mk(20'h30004, 4, 0), 0, 0, "R8");
    repeat (3) @(negedge clk);
    chk("R9", "writebacks outstanding", q_wb.size(), 0);
    chk("R10", "responses outstanding", q_rsp.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule